// File: doc/BRIEF.md
# Multi-Polynomial Randomized LFSR Word Generator

This block produces 16-bit pseudorandom words for a small tag-class device. A 16-bit shift register forms its new bit from a feedback mask. That mask is not fixed. A decoding matrix chooses it from a table of feedback polynomials that is set when the block is built. The table row in use is picked by a circular one-hot selector. The selector moves after every `PERIOD` register steps. The size of each move, one or two positions, depends on an externally supplied true-random bit that is sampled at that moment. Because the feedback law keeps changing under physical randomness, the output stream cannot be modelled as one linear recurrence.

The host first seeds the register. It then raises `req` for one cycle. While `en` is high, the block steps the register sixteen times. It then presents the register contents on `word` and pulses `word_valid` for one cycle. Lowering `en` pauses a word in progress without losing its place.

Top module: `mprng_top`

## Requirements
- R1: While reset is asserted and right after it, `word` equals the constant `ZERO_FIX` (default 16'hACE1), `word_valid` is 0, the selector is at table row 0 and the period count is 0.
- R2: A cycle with `seed_load` high and a nonzero `seed` makes `word` equal that seed from the next cycle on. The load also cancels any word in progress, and no strobe follows for that word.
- R3: Loading a zero seed places `ZERO_FIX` in the register instead, so the register never holds zero.
- R4: One step computes the XOR of all register bits whose positions are set in the active mask. It shifts the register one place toward the MSB and puts that XOR into bit 0. `word` always shows the register.
- R5: The active mask is table row k, where k is the position of the single set bit of the selector. The default table, rows 0..7, is 16'hD008, 16'hB400, 16'h8805, 16'h8016, 16'h9C00, 16'hC090, 16'hA840, 16'h8A24.
- R6: On every `PERIOD`-th step counted from reset, the selector moves from row k to row (k+1) mod NPOLY if `trn_bit` is 0, and to row (k+2) mod NPOLY if it is 1. The step in which it moves still uses row k.
- R7: `trn_bit` has no effect in any cycle other than a selector-update step.
- R8: A `req` pulse seen while idle, with no seed load in the same cycle, starts a word. The next sixteen cycles with `en` high each step the register. Right after the sixteenth step, `word_valid` is high for exactly one cycle while `word` holds the result.
- R9: While `en` is low, no step occurs, and the register, selector and counts are unchanged.
- R10: A `req` seen while a word is in progress has no effect.
- R11: After reset, the register is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Step enable for a word in progress |
| seed_load | input | 1 | Load `seed` into the register |
| seed | input | W | Seed value |
| trn_bit | input | 1 | True-random bit, sampled on selector updates |
| req | input | 1 | Request a new word |
| word | output | W | Register contents |
| word_valid | output | 1 | One-cycle strobe: `word` is a finished word |

## Verification
The bench builds the block with its defaults: eight table rows, an update period of two steps and the 16'hACE1 fallback. With a period of two, every word contains eight selector updates. A few words therefore drive the selector through both move sizes and past the wrap from the last row back to the first. The bench also pauses and cancels words part-way through. It runs the same seed twice under different off-update random bits to show that those bits are ignored.

// File: rtl/mprng_pkg.sv
package mprng_pkg;
   localparam int unsigned MPR_W     = 16;
   localparam int unsigned MPR_NPOLY = 8;

   // Default feedback masks, row 0 at the right; bit i set means register bit i feeds back.
   localparam logic [MPR_NPOLY-1:0][MPR_W-1:0] MPR_DEF_TAPS = {
      16'h8A24, 16'hA840, 16'hC090, 16'h9C00,
      16'h8016, 16'h8805, 16'hB400, 16'hD008
   };

   localparam logic [MPR_W-1:0] MPR_DEF_ZERO_FIX = 16'hACE1;
endpackage

// File: rtl/mprng_selector.sv
module mprng_selector #(
   parameter int unsigned NPOLY  = 8,
   parameter int unsigned PERIOD = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             trn_bit,
   output logic [NPOLY-1:0] sel_oh
);
   localparam int unsigned PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
   localparam logic [PW-1:0] PLAST = PW'(PERIOD - 1);

   logic [PW-1:0]    pcnt_q;
   logic [NPOLY-1:0] rot1, rot2;
   logic             upd;

   assign rot1 = {sel_oh[NPOLY-2:0], sel_oh[NPOLY-1]};
   assign rot2 = {sel_oh[NPOLY-3:0], sel_oh[NPOLY-1:NPOLY-2]};
   assign upd  = step && (pcnt_q == PLAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt_q <= '0;
         sel_oh <= NPOLY'(1);
      end else if (step) begin
         pcnt_q <= upd ? '0 : pcnt_q + 1'b1;
         if (upd) sel_oh <= trn_bit ? rot2 : rot1;
      end
   end
endmodule

// File: rtl/mprng_tap_decode.sv
module mprng_tap_decode #(
   parameter int unsigned W     = 16,
   parameter int unsigned NPOLY = 8,
   parameter logic [NPOLY-1:0][W-1:0] TAPS = '0
) (
   input  logic [NPOLY-1:0] sel_oh,
   output logic [W-1:0]     mask
);
   logic [NPOLY:0][W-1:0] acc;
   assign acc[0] = '0;

   for (genvar g = 0; g < NPOLY; g++) begin : g_row
      assign acc[g+1] = acc[g] | (sel_oh[g] ? TAPS[g] : '0);
   end

   assign mask = acc[NPOLY];
endmodule

// File: rtl/mprng_shift.sv
module mprng_shift #(
   parameter int unsigned W = 16,
   parameter logic [W-1:0] ZERO_FIX = 16'hACE1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] seed,
   input  logic         step,
   input  logic [W-1:0] mask,
   output logic [W-1:0] state
);
   logic fb;
   assign fb = ^(state & mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       state <= ZERO_FIX;
      else if (load)    state <= (seed == '0) ? ZERO_FIX : seed;
      else if (step)    state <= {state[W-2:0], fb};
   end
endmodule

// File: rtl/mprng_word_ctrl.sv
module mprng_word_ctrl #(
   parameter int unsigned W = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic seed_load,
   input  logic req,
   output logic step,
   output logic word_valid
);
   localparam int unsigned CW = $clog2(W);
   localparam logic [CW-1:0] CLAST = CW'(W - 1);

   logic          busy_q;
   logic [CW-1:0] cnt_q;
   logic          last;

   assign step = busy_q && en && !seed_load;
   assign last = step && (cnt_q == CLAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         cnt_q      <= '0;
         word_valid <= 1'b0;
      end else begin
         word_valid <= last;
         if (seed_load)          busy_q <= 1'b0;
         else if (last)          busy_q <= 1'b0;
         else if (!busy_q && req) busy_q <= 1'b1;
         if (!busy_q)            cnt_q <= '0;
         else if (step)          cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/mprng_top.sv
module mprng_top
   import mprng_pkg::*;
#(
   parameter int unsigned W        = MPR_W,
   parameter int unsigned NPOLY    = MPR_NPOLY,
   parameter int unsigned PERIOD   = 2,
   parameter logic [NPOLY-1:0][W-1:0] TAPS = MPR_DEF_TAPS,
   parameter logic [W-1:0] ZERO_FIX = MPR_DEF_ZERO_FIX
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         seed_load,
   input  logic [W-1:0] seed,
   input  logic         trn_bit,
   input  logic         req,
   output logic [W-1:0] word,
   output logic         word_valid
);
   if (NPOLY < 3)      begin : g_chk_np $error("NPOLY must be at least 3"); end
   if (PERIOD < 1)     begin : g_chk_pd $error("PERIOD must be at least 1"); end
   if (W < 4)          begin : g_chk_w  $error("W must be at least 4"); end
   if (ZERO_FIX == '0) begin : g_chk_zf $error("ZERO_FIX must be nonzero"); end
   for (genvar g = 0; g < NPOLY; g++) begin : g_chk_taps
      if (TAPS[g][W-1] != 1'b1) begin : g_bad $error("every mask needs its top bit"); end
   end

   logic             step;
   logic [NPOLY-1:0] sel_oh;
   logic [W-1:0]     mask;

   mprng_word_ctrl #(.W(W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .en(en), .seed_load(seed_load), .req(req),
      .step(step), .word_valid(word_valid)
   );

   mprng_selector #(.NPOLY(NPOLY), .PERIOD(PERIOD)) u_sel (
      .clk(clk), .rst_n(rst_n), .step(step), .trn_bit(trn_bit), .sel_oh(sel_oh)
   );

   mprng_tap_decode #(.W(W), .NPOLY(NPOLY), .TAPS(TAPS)) u_dec (
      .sel_oh(sel_oh), .mask(mask)
   );

   mprng_shift #(.W(W), .ZERO_FIX(ZERO_FIX)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(seed_load), .seed(seed),
      .step(step), .mask(mask), .state(word)
   );
endmodule

// File: rtl/mprng_chk.sv
module mprng_chk #(
   parameter int unsigned W     = 16,
   parameter int unsigned NPOLY = 8,
   parameter logic [W-1:0] ZERO_FIX = 16'hACE1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             seed_load,
   input logic [W-1:0]     seed,
   input logic [W-1:0]     word,
   input logic             word_valid,
   input logic [NPOLY-1:0] sel_oh
);
   a_r11_nonzero: assert property (@(posedge clk) disable iff (!rst_n) word != '0);
   a_r5_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n) $countones(sel_oh) == 1);
   a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n) word_valid |=> !word_valid);
   a_r2_seed_load: assert property (@(posedge clk) disable iff (!rst_n)
      (seed_load && seed != '0) |=> (word == $past(seed)));
   a_r3_zero_seed: assert property (@(posedge clk) disable iff (!rst_n)
      (seed_load && seed == '0) |=> (word == ZERO_FIX));
   a_r9_pause: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !seed_load) |=> ($stable(word) && $stable(sel_oh) && !word_valid));
   a_r2_load_no_strobe: assert property (@(posedge clk) disable iff (!rst_n) seed_load |=> !word_valid);
endmodule

bind mprng_top mprng_chk #(.W(W), .NPOLY(NPOLY), .ZERO_FIX(ZERO_FIX)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .seed_load(seed_load), .seed(seed),
   .word(word), .word_valid(word_valid), .sel_oh(sel_oh)
);

// File: tb/test_mprng_top.sv
module test_mprng_top;
   localparam int PER = 2;
   localparam int NP  = 8;
   localparam logic [15:0] FIX = 16'hACE1;
   localparam logic [15:0] TB_TAPS [8] = '{16'hD008, 16'hB400, 16'h8805, 16'h8016,
                                           16'h9C00, 16'hC090, 16'hA840, 16'h8A24};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, seed_load = 1'b0, trn_bit = 1'b0, req = 1'b0;
   logic [15:0] seed = '0;
   logic [15:0] word;
   logic word_valid;

   int total = 0, bad = 0;
   bit done = 1'b0;

   logic [15:0] m_st;
   int m_idx, m_pcnt, m_bcnt;
   bit m_busy, m_valid;

   always #5 clk = ~clk;

   mprng_top i_mprng_top (
      .clk(clk), .rst_n(rst_n), .en(en), .seed_load(seed_load), .seed(seed),
      .trn_bit(trn_bit), .req(req), .word(word), .word_valid(word_valid)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic void model();
      logic fb;
      if (!rst_n) begin
         m_st = FIX; m_idx = 0; m_pcnt = 0; m_bcnt = 0; m_busy = 0; m_valid = 0;
         return;
      end
      m_valid = 0;
      if (seed_load) begin
         m_st = (seed == 16'h0) ? FIX : seed;
         m_busy = 0;
      end else if (m_busy) begin
         if (en) begin
            fb = ^(m_st & TB_TAPS[m_idx]);
            m_st = {m_st[14:0], fb};
            if (m_pcnt == PER - 1) begin
               m_pcnt = 0;
               m_idx = (m_idx + (trn_bit ? 2 : 1)) % NP;
            end else m_pcnt++;
            m_bcnt++;
            if (m_bcnt == 16) begin m_busy = 0; m_valid = 1; end
         end
      end else if (req) begin
         m_busy = 1; m_bcnt = 0;
      end
   endfunction

   // every cycle: R4/R5/R6 through word, R8 through strobe
   task automatic cyc();
      @(posedge clk);
      model();
      @(negedge clk);
      chk(word === m_st, "R4 word vs model", 32'(word), 32'(m_st));
      chk(word_valid === m_valid, "R8 strobe vs model", 32'(word_valid), 32'(m_valid));
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) cyc();
      rst_n = 1'b1;
   endtask

   task automatic load(input logic [15:0] s);
      seed_load = 1'b1; seed = s;
      cyc();
      seed_load = 1'b0;
   endtask

   // mode 0: pattern on all cycles; mode 1/2: fixed bits on update steps, 0/1 elsewhere
   task automatic gen_word(input logic [31:0] pat, input int mode, output logic [15:0] res);
      int k = 0;
      req = 1'b1;
      cyc();
      req = 1'b0;
      for (int i = 0; i < 60; i++) begin
         if (mode == 0) trn_bit = pat[k % 32];
         else trn_bit = (m_pcnt == PER - 1) ? pat[k % 32] : (mode == 2);
         k++;
         cyc();
         if (m_valid) break;
      end
      chk(word_valid === 1'b1, "R8 strobe after word", 32'(word_valid), 32'd1);
      res = word;
      cyc();
      chk(word_valid === 1'b0, "R8 strobe one cycle", 32'(word_valid), 32'd0);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] r, w1, w2;
      do_reset();
      chk(word === FIX, "R1 reset word", 32'(word), 32'(FIX));
      chk(word_valid === 1'b0, "R1 reset strobe", 32'(word_valid), 32'd0);

      load(16'h1234);
      chk(word === 16'h1234, "R2 seed load", 32'(word), 32'h1234);

      en = 1'b1;
      gen_word(32'h0, 0, r);            // R6 all single moves
      gen_word(32'hFFFF_FFFF, 0, r);    // R6 all double moves, wraps selector
      gen_word(32'h5A3C_96E1, 0, r);    // R5 mixed rows
      chk(r !== 16'h0, "R11 word nonzero", 32'(r), 32'h1);

      // R9: pause mid word
      req = 1'b1; cyc(); req = 1'b0;
      repeat (5) cyc();
      en = 1'b0;
      r = word;
      repeat (6) begin trn_bit = ~trn_bit; cyc(); end
      chk(word === r, "R9 paused word stable", 32'(word), 32'(r));
      en = 1'b1;
      for (int i = 0; i < 30 && !m_valid; i++) cyc();
      chk(word_valid === 1'b1, "R9 resumed word completes", 32'(word_valid), 32'd1);
      cyc();

      // R10: request while busy ignored
      req = 1'b1; cyc();
      repeat (4) cyc();
      req = 1'b0;
      for (int i = 0; i < 30 && !m_valid; i++) cyc();
      chk(word_valid === 1'b1, "R10 single word from held req", 32'(word_valid), 32'd1);
      repeat (3) cyc();

      // R2: seed load cancels burst
      req = 1'b1; cyc(); req = 1'b0;
      repeat (7) cyc();
      load(16'hBEEF);
      chk(word === 16'hBEEF, "R2 load mid word", 32'(word), 32'hBEEF);
      repeat (20) begin
         cyc();
         chk(word_valid === 1'b0, "R2 cancelled word no strobe", 32'(word_valid), 32'd0);
      end

      // R3: zero seed
      load(16'h0000);
      chk(word === FIX, "R3 zero seed fallback", 32'(word), 32'(FIX));
      gen_word(32'hC3A5_0F71, 0, r);

      // R7: off-update random bits have no effect
      do_reset();
      en = 1'b1;
      load(16'h7E11);
      gen_word(32'h9B2D_4E6A, 1, w1);
      do_reset();
      en = 1'b1;
      load(16'h7E11);
      gen_word(32'h9B2D_4E6A, 2, w2);
      chk(w1 === w2, "R7 trn ignored off update", 32'(w2), 32'(w1));

      // R1 again: reset mid word
      req = 1'b1; cyc(); req = 1'b0;
      repeat (3) cyc();
      do_reset();
      chk(word === FIX, "R1 reset mid word", 32'(word), 32'(FIX));
      cyc();
      chk(word_valid === 1'b0, "R1 no strobe after reset", 32'(word_valid), 32'd0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule